// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block turns pin activity on a small microcontroller's external interrupt inputs into latched requests for the CPU. It watches three kinds of input. One pin cannot be masked. Four request pins each have their own vector. Six wake-up pins share a single vector. Every input first passes through a synchronizer. Each maskable pin then has three controls that software sets: which edge it reacts to, whether the pin is used as an interrupt at all, and a flag that records a detected edge.

The CPU sees one request line and a vector index. The index names the most urgent enabled source that is pending. The CPU supplies its global mask bit and a one-cycle accept strobe. When the CPU accepts the non-maskable request, the block clears it. When it accepts a vectored pin request, the block pulses an output that tells the CPU to set its mask bit. Software reads the configuration and the flags over a small single-cycle register bus, and writes a 0 to a flag bit to clear it.

Top module: `ext_irq_edge_ctl`

## Requirements
- R1: Each pin passes through two flip-flops before edge detection. A pin change driven after clock edge k shows in a flag, or in the non-maskable pending state, after clock edge k+3 and not before.
- R2: A falling edge on `nmi_pin` makes a request pending. That request drives `int_req` high with vector 0, whatever `cpu_mask` is and whatever else is pending. It stays pending until `cpu_ack` is high while vector 0 is presented.
- R3: Each request pin has its own polarity bit at address 0, bit i for pin i: 1 selects the rising edge and 0 the falling edge. The other edge of that pin sets no flag.
- R4: A flag can only be set while the pin's function-enable bit is 1 (address 2 for request pins, address 3 for wake pins). An edge is ignored in any cycle in which that pin group's polarity or function-enable register is written. Changing a polarity bit while the pin is steady sets no flag.
- R5: The enable register is at address 4. Bit i (i = 0..3) masks request pin i when 0, and its flag still reads back as 1.
- R6: Each wake pin has its own polarity bit (address 1; 1 = rising), function-enable bit and flag (address 6). All six flags share vector 5, and bit 4 of the enable register masks all of them together.
- R7: Writing a flag register clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1. If an edge arrives in the same cycle as a clear, the flag ends up set.
- R8: Priority runs from the non-maskable request (vector 0) down through request pin 0 (vector 1), pins 1 to 3 (vectors 2 to 4) and then the wake group (vector 5). `int_req` is 0 when nothing enabled is pending.
- R9: While `cpu_mask` is 1, pending maskable sources do not raise `int_req`.
- R10: `mask_set` is 1 exactly when `cpu_ack` is high while `int_req` presents vector 1 to 4. It is 0 when the non-maskable or the wake vector is accepted.
- R11: After reset all configuration registers, flags and the non-maskable pending state are 0, and `int_req` and `mask_set` are 0.
- R12: Reads are combinational. Request-pin flags are at address 5, and unused addresses and high bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable interrupt pin |
| irq_pin | input | 4 | Vectored request pins |
| wk_pin | input | 6 | Wake-up pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| cpu_mask | input | 1 | CPU global interrupt-mask bit |
| cpu_ack | input | 1 | CPU accept strobe |
| int_req | output | 1 | Interrupt request to the CPU |
| int_vec | output | 3 | Vector index of the presented request |
| mask_set | output | 1 | Tells the CPU to set its mask bit |

## Verification
A flag or the non-maskable pending state registers at the third clock edge after the pin moves. Each table row therefore changes the pins just after a rising edge and samples at a falling edge four edges later. The same-cycle race test counts edges exactly: it reads the flag as still 0 between the second and third edge, and as 1 after the third. Register writes take effect at the edge that ends the write cycle. `int_req`, `int_vec`, `mask_set` and `reg_rdata` are combinational, so they are checked at the falling edge of the same cycle.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] RA_IRQ_POL = 3'd0;
   localparam logic [ADDR_W-1:0] RA_WK_POL  = 3'd1;
   localparam logic [ADDR_W-1:0] RA_IRQ_FN  = 3'd2;
   localparam logic [ADDR_W-1:0] RA_WK_FN   = 3'd3;
   localparam logic [ADDR_W-1:0] RA_EN      = 3'd4;
   localparam logic [ADDR_W-1:0] RA_IRQ_FLG = 3'd5;
   localparam logic [ADDR_W-1:0] RA_WK_FLG  = 3'd6;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial assert (STAGES >= 2) else $error("eic_sync: STAGES must be >= 2");

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/eic_edge_flag.sv
module eic_edge_flag #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] fn_en,
   input  logic         cfg_wr,
   input  logic         clr_wr,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] flag
);
   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= smp;
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic hit;
      logic drop;
      assign hit  = (pol[i] ? (smp[i] & ~prev[i]) : (~smp[i] & prev[i]))
                    & fn_en[i] & ~cfg_wr;
      assign drop = clr_wr & ~clr_data[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    flag[i] <= 1'b0;
         else if (hit)  flag[i] <= 1'b1;
         else if (drop) flag[i] <= 1'b0;
      end

      // R7: a flag only falls after a clear write with a 0 in its bit
      a_r7_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flag[i]) |-> $past(clr_wr && !clr_data[i]));
      // R4: a flag only rises when its function was enabled and no config write was under way
      a_r4_rise_needs_fn: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(fn_en[i] && !cfg_wr));
      // R3: a flag rises only after the selected edge of the synchronized sample
      a_r3_edge_match: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag[i]) |-> $past(pol[i] ? (smp[i] && !prev[i]) : (!smp[i] && prev[i])));
   end
endmodule

// File: rtl/eic_prio.sv
module eic_prio #(
   parameter int NUM_IRQ = 4,
   parameter int VEC_W   = 3
) (
   input  logic               nmi,
   input  logic [NUM_IRQ-1:0] irq_act,
   input  logic               wk_act,
   output logic               req,
   output logic [VEC_W-1:0]   vec
);
   localparam logic [VEC_W-1:0] VEC_WK = VEC_W'(NUM_IRQ + 1);

   always_comb begin
      vec = '0;
      if (wk_act) vec = VEC_WK;
      for (int i = NUM_IRQ - 1; i >= 0; i--)
         if (irq_act[i]) vec = VEC_W'(i + 1);
      if (nmi) vec = '0;
   end

   assign req = nmi | (|irq_act) | wk_act;
endmodule

// File: rtl/ext_irq_edge_ctl.sv
module ext_irq_edge_ctl
   import eic_pkg::*;
#(
   parameter int NUM_IRQ     = 4,
   parameter int NUM_WK      = 6,
   parameter int DW          = 8,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = $clog2(NUM_IRQ + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nmi_pin,
   input  logic [NUM_IRQ-1:0] irq_pin,
   input  logic [NUM_WK-1:0]  wk_pin,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DW-1:0]      reg_wdata,
   output logic [DW-1:0]      reg_rdata,
   input  logic               cpu_mask,
   input  logic               cpu_ack,
   output logic               int_req,
   output logic [VEC_W-1:0]   int_vec,
   output logic               mask_set
);
   localparam int PW = 1 + NUM_WK + NUM_IRQ;
   localparam int EW = NUM_IRQ + 1;

   initial assert (EW < DW && NUM_WK < DW && NUM_IRQ >= 1)
      else $error("ext_irq_edge_ctl: register fields exceed data width");
   initial assert ((1 << VEC_W) >= NUM_IRQ + 2)
      else $error("ext_irq_edge_ctl: VEC_W too small");

   logic [PW-1:0]      pins_s;
   logic [NUM_IRQ-1:0] irq_s, irq_pol, irq_fn, irq_flag;
   logic [NUM_WK-1:0]  wk_s, wk_pol, wk_fn, wk_flag;
   logic [EW-1:0]      en_reg;
   logic               nmi_s, nmi_prev, nmi_pend;
   logic               unused_wd;

   eic_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({nmi_pin, wk_pin, irq_pin}), .q(pins_s));

   assign irq_s = pins_s[NUM_IRQ-1:0];
   assign wk_s  = pins_s[NUM_IRQ +: NUM_WK];
   assign nmi_s = pins_s[PW-1];
   assign unused_wd = ^reg_wdata[DW-1:NUM_WK];

   // ---------------- configuration registers ----------------
   logic wr_irq_pol, wr_wk_pol, wr_irq_fn, wr_wk_fn, wr_en, wr_irq_flg, wr_wk_flg;
   assign wr_irq_pol = reg_wr && reg_addr == RA_IRQ_POL;
   assign wr_wk_pol  = reg_wr && reg_addr == RA_WK_POL;
   assign wr_irq_fn  = reg_wr && reg_addr == RA_IRQ_FN;
   assign wr_wk_fn   = reg_wr && reg_addr == RA_WK_FN;
   assign wr_en      = reg_wr && reg_addr == RA_EN;
   assign wr_irq_flg = reg_wr && reg_addr == RA_IRQ_FLG;
   assign wr_wk_flg  = reg_wr && reg_addr == RA_WK_FLG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pol <= '0; wk_pol <= '0; irq_fn <= '0; wk_fn <= '0; en_reg <= '0;
      end else begin
         if (wr_irq_pol) irq_pol <= reg_wdata[NUM_IRQ-1:0];
         if (wr_wk_pol)  wk_pol  <= reg_wdata[NUM_WK-1:0];
         if (wr_irq_fn)  irq_fn  <= reg_wdata[NUM_IRQ-1:0];
         if (wr_wk_fn)   wk_fn   <= reg_wdata[NUM_WK-1:0];
         if (wr_en)      en_reg  <= reg_wdata[EW-1:0];
      end
   end

   // ---------------- edge detection and flags ----------------
   eic_edge_flag #(.W(NUM_IRQ)) u_irq_flags (
      .clk(clk), .rst_n(rst_n), .smp(irq_s), .pol(irq_pol), .fn_en(irq_fn),
      .cfg_wr(wr_irq_pol | wr_irq_fn), .clr_wr(wr_irq_flg),
      .clr_data(reg_wdata[NUM_IRQ-1:0]), .flag(irq_flag));

   eic_edge_flag #(.W(NUM_WK)) u_wk_flags (
      .clk(clk), .rst_n(rst_n), .smp(wk_s), .pol(wk_pol), .fn_en(wk_fn),
      .cfg_wr(wr_wk_pol | wr_wk_fn), .clr_wr(wr_wk_flg),
      .clr_data(reg_wdata[NUM_WK-1:0]), .flag(wk_flag));

   // ---------------- non-maskable input ----------------
   logic nmi_take;
   assign nmi_take = cpu_ack && int_req && int_vec == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev <= 1'b0;
         nmi_pend <= 1'b0;
      end else begin
         nmi_prev <= nmi_s;
         if (nmi_prev && !nmi_s) nmi_pend <= 1'b1;
         else if (nmi_take)      nmi_pend <= 1'b0;
      end
   end

   // ---------------- priority and CPU handshake ----------------
   logic [NUM_IRQ-1:0] irq_act;
   logic               wk_act;
   assign irq_act = irq_flag & en_reg[NUM_IRQ-1:0] & {NUM_IRQ{~cpu_mask}};
   assign wk_act  = (|wk_flag) & en_reg[NUM_IRQ] & ~cpu_mask;

   eic_prio #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) u_prio (
      .nmi(nmi_pend), .irq_act(irq_act), .wk_act(wk_act),
      .req(int_req), .vec(int_vec));

   assign mask_set = cpu_ack && int_req && int_vec != '0
                     && int_vec <= VEC_W'(NUM_IRQ);

   // ---------------- register read ----------------
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_IRQ_POL: reg_rdata[NUM_IRQ-1:0] = irq_pol;
         RA_WK_POL:  reg_rdata[NUM_WK-1:0]  = wk_pol;
         RA_IRQ_FN:  reg_rdata[NUM_IRQ-1:0] = irq_fn;
         RA_WK_FN:   reg_rdata[NUM_WK-1:0]  = wk_fn;
         RA_EN:      reg_rdata[EW-1:0]      = en_reg;
         RA_IRQ_FLG: reg_rdata[NUM_IRQ-1:0] = irq_flag;
         RA_WK_FLG:  reg_rdata[NUM_WK-1:0]  = wk_flag;
         default:    reg_rdata = '0;
      endcase
   end

   // ---------------- assertions ----------------
   // R2: a pending non-maskable request is always presented on vector 0
   a_r2_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_pend |-> (int_req && int_vec == '0));
   // R2: it stays pending until accepted
   a_r2_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_pend && !cpu_ack) |=> nmi_pend);
   // R9: the global mask blocks every maskable source
   a_r9_cpu_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_mask && !nmi_pend) |-> !int_req);
   // R6: a cleared group enable keeps the wake vector off the output
   a_r6_group_off: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req && !en_reg[NUM_IRQ]) |-> int_vec != VEC_W'(NUM_IRQ + 1));
   // R10: the mask pulse only appears with an accept
   a_r10_mask_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mask_set |-> (cpu_ack && !nmi_pend));
   // R8: nothing pending and enabled means no request
   a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!nmi_pend && !(|(irq_flag & en_reg[NUM_IRQ-1:0])) && !((|wk_flag) && en_reg[NUM_IRQ]))
      |-> !int_req);
endmodule

// File: tb/sim_ext_irq_edge_ctl.sv
module sim_ext_irq_edge_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nmi_pin = 1'b1;
   logic [3:0] irq_pin = '0;
   logic [5:0] wk_pin = '0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       cpu_mask = 1'b0;
   logic       cpu_ack = 1'b0;
   logic       int_req;
   logic [2:0] int_vec;
   logic       mask_set;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   ext_irq_edge_ctl u0 (
      .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .irq_pin(irq_pin), .wk_pin(wk_pin),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_mask(cpu_mask), .cpu_ack(cpu_ack), .int_req(int_req), .int_vec(int_vec),
      .mask_set(mask_set));

   // fields: irq[23:20] wk[19:14] exp_irq_flag[13:10] exp_wk_flag[9:4] exp_req[3] exp_vec[2:0]
   localparam logic [23:0] TBL [8] = '{
      24'b0001_000000_0001_000000_1_001,
      24'b1111_000000_0000_000000_0_000,
      24'b0101_000000_1010_000000_1_010,
      24'b0101_111111_0000_110011_1_101,
      24'b0100_001100_0000_000000_0_000,
      24'b0100_000000_0000_001100_1_101,
      24'b1000_000000_0000_000000_0_000,
      24'b0000_000000_1000_000000_1_100
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a; #0.5;
      d = reg_rdata;
   endtask

   task automatic pins(input logic [3:0] ip, input logic [5:0] wp);
      @(posedge clk); #1;
      irq_pin = ip; wk_pin = wp;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      check("R11 req", int_req, 0);
      check("R11 mask_set", mask_set, 0);
      rd(3'd5, d); check("R11 irq flags", d, 0);
      rd(3'd4, d); check("R11 enables", d, 0);
      rst_n = 1'b1;

      wr(3'd0, 8'b0000_0101);   // irq polarity
      wr(3'd1, 8'b0011_0011);   // wake polarity
      wr(3'd2, 8'b0000_1011);   // irq function (pin 2 off)
      wr(3'd3, 8'b0011_1111);   // wake function
      wr(3'd4, 8'b0001_1111);   // enables
      rd(3'd2, d); check("R12 fn readback", d, 8'h0b);
      rd(3'd7, d); check("R12 unused addr", d, 0);

      // table walk: R3 R4 R6 R8
      for (int r = 0; r < 8; r++) begin
         logic [23:0] t;
         t = TBL[r];
         pins(t[23:20], t[19:14]);
         rd(3'd5, d); check($sformatf("R3 row%0d irq flags", r), d, t[13:10]);
         rd(3'd6, d); check($sformatf("R6 row%0d wake flags", r), d, t[9:4]);
         check($sformatf("R8 row%0d req", r), int_req, t[3]);
         if (t[3]) check($sformatf("R8 row%0d vec", r), int_vec, t[2:0]);
         wr(3'd5, 8'h00);
         wr(3'd6, 8'h00);
      end

      // R8 / R5 / R6: priority and masking
      pins(4'b0001, 6'b000001);
      check("R8 irq0 over wake", int_vec, 1);
      wr(3'd4, 8'b0001_1110);
      @(negedge clk);
      check("R5 masked irq0 gives wake", int_vec, 5);
      rd(3'd5, d); check("R5 flag kept", d, 1);
      wr(3'd4, 8'b0000_1110);
      @(negedge clk);
      check("R6 group enable off", int_req, 0);
      rd(3'd6, d); check("R6 wake flag kept", d, 1);
      wr(3'd4, 8'b0001_1111);

      // R9 global mask, R2 non-maskable
      cpu_mask = 1'b1;
      @(negedge clk);
      check("R9 masked", int_req, 0);
      @(posedge clk); #1; nmi_pin = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1 nmi not yet", int_req, 0);
      @(posedge clk); @(negedge clk);
      check("R2 nmi req under mask", int_req, 1);
      check("R2 nmi vec", int_vec, 0);
      cpu_ack = 1'b1; #0.5;
      check("R10 no mask_set on nmi", mask_set, 0);
      @(posedge clk); #1; cpu_ack = 1'b0;
      @(negedge clk);
      check("R2 nmi cleared by accept", int_req, 0);
      cpu_mask = 1'b0;
      @(negedge clk);
      check("R8 irq0 after nmi", int_vec, 1);
      cpu_ack = 1'b1; #0.5;
      check("R10 mask_set on irq", mask_set, 1);
      @(posedge clk); #1; cpu_ack = 1'b0;
      @(negedge clk);
      check("R10 flag stays after accept", int_vec, 1);

      // R7 clear semantics
      wr(3'd6, 8'b0000_0001);
      rd(3'd6, d); check("R7 write 1 keeps", d, 1);
      wr(3'd6, 8'h00);
      wr(3'd5, 8'b0000_1110);
      rd(3'd5, d); check("R7 write 0 clears", d, 0);

      // R7 set wins, with R1 latency
      pins(4'b0000, 6'b000000);
      @(posedge clk); #1; irq_pin = 4'b0001;
      @(posedge clk); @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h00;
      @(negedge clk);
      check("R1 flag not before third edge", reg_rdata, 0);
      @(posedge clk); #1; reg_wr = 1'b0;
      rd(3'd5, d); check("R7 set wins over clear", d, 1);
      wr(3'd5, 8'h00);

      // R4 function enable and polarity change
      wr(3'd2, 8'b0000_1010);
      pins(4'b0000, 6'b000000);
      pins(4'b0001, 6'b000000);
      rd(3'd5, d); check("R4 fn off no flag", d, 0);
      wr(3'd2, 8'b0000_1011);
      wr(3'd0, 8'b0000_0100);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd(3'd5, d); check("R4 polarity flip no flag", d, 0);
      pins(4'b0000, 6'b000000);
      rd(3'd5, d); check("R3 new falling polarity", d, 1);

      finish_run();
   end
endmodule